// File: doc/BRIEF.md
# Triggered Multi-Source Event Builder

When a trigger accept arrives, this block gathers one fragment from each of seven input streams. Five streams carry readout data and two carry trigger-board data. It sends them downstream as a single framed event. The event opens with two header words that carry a 24-bit event number. The fragments follow, always in the same source order. Two trailer words close the event. The first trailer word reports which enabled sources failed to deliver in time. The second holds a 16-bit CRC, updated one whole word per cycle, over the header and all payload words.

Each source stream and the output stream use a valid/ready handshake. A word moves when valid and ready are both high on a rising clock edge. The output never drops a word. When `out_ready` is low, the word offered as header or trailer stays on `out_data` and `out_valid` stays high. While a source is being forwarded, its `src_ready` follows `out_ready`, so back-pressure passes straight through to that one source. Every other source sees `src_ready` low. A fragment ends with the word whose `src_last` bit is high. The control inputs `trig`, `cnt_clear`, `src_en` and `tmo_limit` are plain level or pulse pins.

A source counts as waiting when it is enabled and its valid is low. If it waits for `tmo_limit` consecutive cycles with no word offered, it is abandoned and flagged as missing. A source that is disabled is stepped over without a flag.

Top module: `event_builder`

## Requirements
- R1: A high `trig` while `busy` is low starts an event, and `busy` is high from the next clock edge. A `trig` while `busy` is high is ignored and does not advance the event number.
- R2: The event number is a 24-bit counter that adds one for each accepted trigger, so the first event after reset is number 1. A `cnt_clear` pulse sets it to 0. A `cnt_clear` in the same cycle as an accepted trigger gives that event number 1.
- R3: The header is two words. The first is {8'hEB, number[23:16]} and the second is number[15:0].
- R4: Fragments are forwarded in source order 0 to 6, up to and including the `src_last` word. Sources 0–4 are the data sources and 5–6 are the trigger sources. Source i uses `src_data[16*i+15:16*i]`.
- R5: A source whose `src_en` bit is low is skipped. Its `src_ready` is never raised and its missing bit stays clear.
- R6: An enabled source that offers no word for `tmo_limit` consecutive cycles is abandoned, and bit i of the missing field is set.
- R7: The first trailer word is {9'h1CE, missing[6:0]}, with bit i standing for source i. `out_last` is high only on the second trailer word.
- R8: The second trailer word is a CRC with polynomial 0x1021, initial value 0xFFFF, MSB first and no final inversion. It covers both header words and every payload word of the event, and restarts for each event.
- R9: At most one `src_ready` bit is high at a time. A header or trailer word held under `out_ready` low stays stable with `out_valid` high.
- R10: After the last trailer word is accepted, `busy` is low on the next cycle and a new trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger accept pulse |
| cnt_clear | input | 1 | Synchronous clear of the event number |
| src_en | input | 7 | Per-source enable mask |
| tmo_limit | input | 16 | Per-source wait limit in cycles |
| src_valid | input | 7 | Source word valid, one bit per source |
| src_data | input | 112 | Source words, 16 bits per source |
| src_last | input | 7 | Marks the final word of a fragment |
| src_ready | output | 7 | Source word taken, one bit per source |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word |
| out_last | output | 1 | Final word of the event |
| out_ready | input | 1 | Downstream ready |
| busy | output | 1 | Event in progress |

## Verification
A stuck or skipped source index shows up at the ports as payload words in the wrong order, or as a `src_ready` on a disabled lane. The scoreboard catches this on the very next output word. A wrong missing bit or a timeout counter that is off appears in the first trailer word. A CRC register that is not restarted, or that misses a word, shows only at the end of that same event, in the last word. A counter that steps on an ignored trigger shows in the header of the following event.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR0, S_HDR1, S_SRC, S_TRL0, S_TRL1
  } eb_state_e;

  // one full word folded into the CRC in a single step
  function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = r[WORD_W-1] ^ d[b];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/eb_evt_counter.sv
module eb_evt_counter #(
  parameter int EVN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [EVN_W-1:0] num
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) num <= '0;
    else        num <= (clr ? '0 : num) + EVN_W'(inc);
  end
endmodule

// File: rtl/eb_crc16.sv
module eb_crc16
  import eb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              en,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (en)   crc <= crc_fold(crc, data);
  end
endmodule

// File: rtl/eb_tmo.sv
module eb_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             waiting,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  assign expire = waiting &&
                  (({1'b0, cnt} + (TMO_W+1)'(1)) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear || expire)  cnt <= '0;
    else if (waiting)          cnt <= cnt + TMO_W'(1);
  end
endmodule

// File: rtl/eb_src_select.sv
module eb_src_select #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic                      active,
  input  logic                      down_ready,
  input  logic [NUM_SRC-1:0]        src_valid,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  input  logic [NUM_SRC-1:0]        src_last,
  output logic                      sel_valid,
  output logic [DATA_W-1:0]         sel_data,
  output logic                      sel_last,
  output logic [NUM_SRC-1:0]        src_ready
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    assign hit[g]       = (idx == IDX_W'(g));
    assign src_ready[g] = active && down_ready && hit[g];
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_last  = 1'b0;
    sel_data  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit[i]) begin
        sel_valid = active && src_valid[i];
        sel_last  = src_last[i];
        sel_data  = src_data[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/event_builder.sv
module event_builder
  import eb_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int EVN_W   = 24,
  parameter int TMO_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig,
  input  logic                      cnt_clear,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [TMO_W-1:0]          tmo_limit,
  input  logic [NUM_SRC-1:0]        src_valid,
  input  logic [NUM_SRC*WORD_W-1:0] src_data,
  input  logic [NUM_SRC-1:0]        src_last,
  output logic [NUM_SRC-1:0]        src_ready,
  output logic                      out_valid,
  output logic [WORD_W-1:0]         out_data,
  output logic                      out_last,
  input  logic                      out_ready,
  output logic                      busy
);
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int HI_W   = EVN_W - WORD_W;
  localparam int HTAG_W = WORD_W - HI_W;
  localparam int TTAG_W = WORD_W - NUM_SRC;
  localparam logic [HTAG_W-1:0] HDR_TAG = HTAG_W'('hEB);
  localparam logic [TTAG_W-1:0] TRL_TAG = TTAG_W'('h1CE);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_SRC - 1);

  eb_state_e          st;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] miss;
  logic [EVN_W-1:0]   evn;
  logic [WORD_W-1:0]  crc;
  logic               accept, active, cur_en, xfer, expire, src_done;
  logic               sel_valid, sel_last, pay_phase;
  logic [WORD_W-1:0]  sel_data;

  assign accept    = trig && (st == S_IDLE);
  assign pay_phase = (st == S_SRC);
  assign cur_en    = src_en[idx];
  assign active    = pay_phase && cur_en;
  assign busy      = (st != S_IDLE);

  eb_evt_counter #(.EVN_W(EVN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(accept), .num(evn)
  );

  eb_src_select #(.NUM_SRC(NUM_SRC), .DATA_W(WORD_W), .IDX_W(IDX_W)) u_sel (
    .idx(idx), .active(active), .down_ready(out_ready),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
    .sel_valid(sel_valid), .sel_data(sel_data), .sel_last(sel_last),
    .src_ready(src_ready)
  );

  eb_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(!active || xfer),
    .waiting(active && !sel_valid), .limit(tmo_limit), .expire(expire)
  );

  eb_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(accept),
    .en(xfer && (st == S_HDR0 || st == S_HDR1 || st == S_SRC)),
    .data(out_data), .crc(crc)
  );

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    case (st)
      S_HDR0: begin out_valid = 1'b1; out_data = {HDR_TAG, evn[EVN_W-1:WORD_W]}; end
      S_HDR1: begin out_valid = 1'b1; out_data = evn[WORD_W-1:0]; end
      S_SRC:  begin out_valid = sel_valid; out_data = sel_data; end
      S_TRL0: begin out_valid = 1'b1; out_data = {TRL_TAG, miss}; end
      S_TRL1: begin out_valid = 1'b1; out_data = crc; out_last = 1'b1; end
      default: ;
    endcase
  end

  assign xfer     = out_valid && out_ready;
  assign src_done = pay_phase && (!cur_en || (xfer && sel_last) || expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      miss <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st   <= S_HDR0;
          idx  <= '0;
          miss <= '0;
        end
        S_HDR0: if (xfer) st <= S_HDR1;
        S_HDR1: if (xfer) st <= S_SRC;
        S_SRC: if (src_done) begin
          if (expire) miss[idx] <= 1'b1;
          if (idx == LAST_IDX) st <= S_TRL0;
          else                 idx <= idx + IDX_W'(1);
        end
        S_TRL0: if (xfer) st <= S_TRL1;
        S_TRL1: if (xfer) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
  parameter int NUM_SRC = 7,
  parameter int EVN_W   = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig,
  input logic               cnt_clear,
  input logic               busy,
  input logic [NUM_SRC-1:0] src_en,
  input logic [NUM_SRC-1:0] src_ready,
  input logic               out_valid,
  input logic [15:0]        out_data,
  input logic               out_last,
  input logic               out_ready,
  input logic               pay_phase,
  input logic [EVN_W-1:0]   evn
);
  // R1
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig && !cnt_clear |=> $stable(evn));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !busy && !cnt_clear |=> evn == EVN_W'($past(evn) + 1));
  // R5
  no_ready_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready & ~src_en) == '0);
  // R9
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready));
  // R9
  hold_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !pay_phase |=> out_valid && $stable(out_data));
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R10
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !busy);
endmodule

bind event_builder eb_checker #(.NUM_SRC(NUM_SRC), .EVN_W(EVN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .cnt_clear(cnt_clear), .busy(busy),
  .src_en(src_en), .src_ready(src_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
  .pay_phase(pay_phase), .evn(evn)
);

// File: tb/sim_event_builder.sv
`timescale 1ns/1ps
module sim_event_builder;
  localparam int NS = 7;
  localparam int TMO = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, cnt_clear = 1'b0, out_ready = 1'b1;
  logic [NS-1:0] src_en = '1;
  logic [15:0] tmo_limit = 16'(TMO);
  logic [NS-1:0] src_valid, src_last, src_ready;
  logic [NS*16-1:0] src_data;
  logic out_valid, out_last, busy;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  event_builder u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cnt_clear(cnt_clear),
    .src_en(src_en), .tmo_limit(tmo_limit), .src_valid(src_valid),
    .src_data(src_data), .src_last(src_last), .src_ready(src_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .busy(busy)
  );

  int checks = 0, fails = 0;
  logic [16:0] expq[$];
  string tagq[$];
  logic [16:0] sbuf [NS][8];
  int slen [NS];
  int spos [NS];
  logic [NS-1:0] took = '0;
  logic [NS-1:0] cur_mask = '1;
  bit bad_ready = 0, stall = 0;
  logic [7:0] lfsr = 8'h5A;
  logic [23:0] exp_num = '0;

  initial for (int i = 0; i < NS; i++) begin slen[i] = 0; spos[i] = 0; end

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      src_valid[i] = spos[i] < slen[i];
      src_data[i*16 +: 16] = src_valid[i] ? sbuf[i][spos[i] & 7][15:0] : 16'h0;
      src_last[i] = src_valid[i] ? sbuf[i][spos[i] & 7][16] : 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench CRC: word xored into the register, then sixteen shifts
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c ^ w;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // monitor and source model
  always @(posedge clk) begin
    took = src_valid & src_ready;
    if ((src_ready & ~cur_mask) != '0) bad_ready = 1;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(0, "R4 unexpected word", {15'd0, out_last, out_data}, 0);
      end else begin
        logic [16:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({out_last, out_data} == e, t, {15'd0, out_last, out_data}, {15'd0, e});
      end
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NS; i++) if (took[i]) spos[i] = spos[i] + 1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall ? lfsr[0] : 1'b1;
  end

  task automatic run_event(input logic [NS-1:0] mask, input logic [NS-1:0] present,
                           input int base, input bit busy_trig, input bit clr_trig);
    logic [15:0] c, w;
    logic [NS-1:0] miss;
    int len;
    exp_num = clr_trig ? 24'd1 : exp_num + 24'd1;
    c = 16'hFFFF;
    miss = '0;
    cur_mask = mask;
    bad_ready = 0;
    src_en = mask;
    w = {8'hEB, exp_num[23:16]};
    expq.push_back({1'b0, w}); tagq.push_back("R3/R2 header word 0"); c = ref_crc(c, w);
    w = exp_num[15:0];
    expq.push_back({1'b0, w}); tagq.push_back("R3/R2 header word 1"); c = ref_crc(c, w);
    for (int i = 0; i < NS; i++) begin
      slen[i] = 0; spos[i] = 0;
      if (mask[i] && present[i]) begin
        len = 1 + ((base + i) % 3);
        for (int k = 0; k < len; k++) begin
          w = {i[2:0], exp_num[4:0], k[7:0]};
          sbuf[i][k] = {(k == len - 1), w};
          expq.push_back({1'b0, w}); tagq.push_back("R4 payload order");
          c = ref_crc(c, w);
        end
        slen[i] = len;
      end else if (mask[i]) miss[i] = 1'b1;
    end
    expq.push_back({1'b0, 9'h1CE, miss}); tagq.push_back("R6/R7 trailer missing field");
    expq.push_back({1'b1, c}); tagq.push_back("R8 trailer CRC");
    trig = 1'b1; cnt_clear = clr_trig;
    @(negedge clk);
    trig = 1'b0; cnt_clear = 1'b0;
    check(busy == 1'b1, "R1 busy after trigger", {31'd0, busy}, 1);
    if (busy_trig) begin
      repeat (3) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
    while (expq.size() != 0) @(negedge clk);
    check(busy == 1'b0, "R10 idle after last word", {31'd0, busy}, 0);
    check(!bad_ready, "R5 ready on disabled source", {31'd0, bad_ready}, 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 run did not finish actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset idle", {31'd0, busy}, 0);
    check(out_valid == 1'b0, "R9 reset no output", {31'd0, out_valid}, 0);
    check(src_ready == '0, "R9 reset no source ready", {25'd0, src_ready}, 0);

    run_event(7'h7F, 7'h7F, 0, 0, 0);        // R4 all sources
    stall = 1;
    run_event(7'h7F, 7'h7F, 1, 0, 0);        // R9 back-pressure
    stall = 0;
    run_event(7'b1010101, 7'h7F, 2, 0, 0);   // R5 disabled sources
    stall = 1;
    run_event(7'h7F, 7'b0111011, 0, 0, 0);   // R6 sources 2 and 6 time out
    stall = 0;
    run_event(7'h7F, 7'h7F, 1, 1, 0);        // R1 trigger during event ignored
    run_event(7'h7F, 7'h7F, 2, 0, 0);        // R2 numbering continues by one
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    exp_num = '0;
    run_event(7'h7F, 7'h7F, 0, 0, 0);        // R2 after clear -> 1
    run_event(7'h7F, 7'h7F, 0, 0, 0);
    run_event(7'h7F, 7'h7F, 1, 0, 1);        // R2 clear with trigger -> 1
    run_event(7'h00, 7'h00, 0, 0, 0);        // R5 everything disabled
    run_event(7'h7F, 7'h00, 0, 0, 0);        // R6 every source missing

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule